// File: doc/BRIEF.md
# Four-Mode Serial Port with Ninth-Bit Framing

This block is a serial port with four operating modes, chosen by a two-bit field in its control register. Mode 0 is a synchronous shifter. It sends a byte out through an external shift register to add parallel outputs, using a fixed bit clock derived from the oscillator. Mode 1 is an asynchronous 8-bit link. Modes 2 and 3 are asynchronous 9-bit links: mode 2 runs at a fixed fraction of the oscillator, and mode 3 is paced by the same external timer-overflow strobe as mode 1. A rate-doubling bit in the control register halves the bit time in modes 1, 2 and 3.

Software reaches the block through a byte-wide register port with two addresses: the data buffer and the control register. Writing the data buffer starts a transmission. Reading it returns the last byte received. The control register holds the mode, the receive enable, the ninth bit to send, the ninth bit received, the two completion flags and the doubling bit. The receiver oversamples the line 16 times per bit and takes a majority vote of three mid-bit samples.

Top module: `multimode_serial`

## Requirements
- R1: After reset, ser_out and shift_clk are 1, tx_flag and rx_flag are 0, and the control register reads 00h.
- R2: In mode 0 (control bits 1:0 = 00), a data-buffer write sends 8 bits on ser_out, LSB first, one bit every SYNC_DIV (12) clocks. Within each bit, shift_clk is low for the first half and high for the second half, and the data is stable at the rising edge. shift_clk is 1 when the port is idle.
- R3: In the asynchronous modes, a frame is: a start bit (0), 8 data bits LSB first, then in modes 2 and 3 a ninth bit taken from control bit 3, then a stop bit (1). A mode 1 frame has no ninth bit.
- R4: In mode 2 (10), one bit lasts FIX_DIV (64) clocks, or 32 clocks when control bit 7 is 1.
- R5: In modes 1 (01) and 3 (11), one bit lasts 32 overflow strobes, or 16 overflow strobes when control bit 7 is 1.
- R6: A data-buffer write made while a frame is being sent is ignored. The frame in progress finishes unchanged, and no second frame follows.
- R7: With control bit 2 set, modes 1 to 3 receive frames. A data-buffer read returns the received byte. Modes 2 and 3 store the received ninth bit in control bit 4. Mode 1 leaves control bit 4 unchanged.
- R8: Each received bit is decided by a majority vote of three samples taken near the middle of the bit, so a single glitch shorter than one sample spacing does not change the received data.
- R9: A start bit that votes 1 is treated as noise. The receiver returns to idle without setting a flag and can then receive the next frame.
- R10: A frame whose stop bit votes 0 is discarded. The data buffer and rx_flag are left unchanged.
- R11: With control bit 2 clear, line activity on rxd changes neither the data buffer nor rx_flag.
- R12: tx_flag (control bit 5) is set when a frame has been sent. rx_flag (control bit 6) is set when a frame has been accepted. Each flag is cleared only by a control write with that bit 0. A control write with that bit 1 leaves the flag as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 data buffer, 1 control register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ovf_strobe | input | 1 | One-cycle timer overflow pulse that paces modes 1 and 3 |
| rxd | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial data out: the transmit line, or the shift data in mode 0 |
| shift_clk | output | 1 | Shift clock for mode 0, held at 1 otherwise |
| tx_flag | output | 1 | Transmit-complete flag |
| rx_flag | output | 1 | Receive-complete flag |

## Verification
The assertions check on every cycle:
- an idle transmitter holds both lines high;
- an asynchronous frame opens with a low start bit;
- each completion flag rises only right after its internal end event and stays set until a clearing control write;
- a frame is accepted only while reception is enabled.

Bit order, the ninth-bit source, bit timing under each rate setting, the majority vote against glitches, false-start and bad-stop rejection, and the ignored write during a send can only be shown by the bench's scenarios. Those scenarios drive and capture whole frames at the pins.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    MD_SHIFT  = 2'd0,
    MD_A8_TMR = 2'd1,
    MD_A9_FIX = 2'd2,
    MD_A9_TMR = 2'd3
  } sp_mode_e;

  // control register bit positions
  localparam int CB_RXEN = 2;
  localparam int CB_TX9  = 3;
  localparam int CB_RX9  = 4;
  localparam int CB_TXF  = 5;
  localparam int CB_RXF  = 6;
  localparam int CB_DBL  = 7;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic nine_bit(input sp_mode_e m);
    return (m == MD_A9_FIX) || (m == MD_A9_TMR);
  endfunction

  function automatic logic timer_paced(input sp_mode_e m);
    return (m == MD_A8_TMR) || (m == MD_A9_TMR);
  endfunction

  // start + 8 data + optional ninth + stop
  function automatic logic [3:0] frame_bits(input sp_mode_e m);
    return nine_bit(m) ? 4'd11 : 4'd10;
  endfunction

  // frame image, bit 0 leaves first; unused top bits idle high
  function automatic logic [10:0] async_frame(input logic [7:0] d, input logic b9, input logic nine);
    return nine ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
  endfunction

endpackage

// File: rtl/sp_tick.sv
module sp_tick import sp_pkg::*; #(
  parameter int FIX_DIV = 64,
  parameter int OVS     = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sp_mode_e mode,
  input  logic     dbl,
  input  logic     ovf,
  output logic     tick
);
  localparam int FSTEP = FIX_DIV / OVS;
  localparam int CW    = (FSTEP > 2) ? $clog2(FSTEP) : 1;
  localparam logic [CW-1:0] F_FULL = CW'(FSTEP - 1);
  localparam logic [CW-1:0] F_HALF = CW'(FSTEP / 2 - 1);

  logic [CW-1:0] fcnt;
  logic [CW-1:0] flast;
  logic          half;

  assign flast = dbl ? F_HALF : F_FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      half <= 1'b0;
    end else begin
      fcnt <= (fcnt >= flast) ? '0 : fcnt + 1'b1;
      if (ovf) half <= ~half;
    end
  end

  // timer-paced: every second overflow, or every overflow when doubled
  assign tick = timer_paced(mode) ? (ovf & (dbl | half)) : (fcnt == flast);

endmodule

// File: rtl/sp_tx.sv
module sp_tx import sp_pkg::*; #(
  parameter int SYNC_DIV = 12,
  parameter int OVS      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sp_mode_e   mode,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] data,
  input  logic       b9,
  output logic       ser_out,
  output logic       shift_clk,
  output logic       busy,
  output logic       done
);
  localparam int PW = $clog2(SYNC_DIV);
  localparam int OW = $clog2(OVS);
  localparam logic [PW-1:0] PH_LAST  = PW'(SYNC_DIV - 1);
  localparam logic [PW-1:0] PH_RISE  = PW'(SYNC_DIV / 2);
  localparam logic [OW-1:0] SUB_LAST = OW'(OVS - 1);

  logic [10:0]   sh;
  logic [3:0]    left;
  logic [PW-1:0] ph;
  logic [OW-1:0] sub;
  logic          sync_m;
  logic          step;

  assign sync_m = (mode == MD_SHIFT);
  assign step   = busy && (sync_m ? (ph == PH_LAST) : (tick && sub == SUB_LAST));
  assign done   = step && (left == 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      ph   <= '0;
      sub  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        ph   <= '0;
        sub  <= '0;
        if (sync_m) begin
          sh   <= {3'b111, data};
          left <= 4'd8;
        end else begin
          sh   <= async_frame(data, b9, nine_bit(mode));
          left <= frame_bits(mode);
        end
      end
    end else begin
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      if (tick) sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
      if (step) begin
        sh   <= {1'b1, sh[10:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end
    end
  end

  assign ser_out   = busy ? sh[0] : 1'b1;
  assign shift_clk = (busy && sync_m) ? (ph >= PH_RISE) : 1'b1;

endmodule

// File: rtl/sp_rx.sv
module sp_rx import sp_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  sp_mode_e   mode,
  input  logic       tick,
  input  logic       rxd,
  output logic [7:0] data,
  output logic       nine,
  output logic       frame_ok
);
  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] SUB_LAST = OW'(OVS - 1);
  localparam logic [OW-1:0] V_A      = OW'(OVS / 2 - 1);
  localparam logic [OW-1:0] V_B      = OW'(OVS / 2);
  localparam logic [OW-1:0] V_C      = OW'(OVS / 2 + 1);

  logic          s1, s2;
  logic          active;
  logic          va, vb;
  logic          bitv;
  logic          decide;
  logic [OW-1:0] sub;
  logic [OW-1:0] idx;
  logic [3:0]    bitn;
  logic [3:0]    stop_n;
  logic [8:0]    sh;

  assign idx      = (sub == SUB_LAST) ? '0 : sub + 1'b1;
  assign stop_n   = frame_bits(mode) - 4'd1;
  assign bitv     = vote3(va, vb, s2);
  assign decide   = active && tick && (idx == V_C);
  assign frame_ok = decide && (bitn == stop_n) && bitv && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      active <= 1'b0;
      sub    <= '0;
      bitn   <= '0;
      va     <= 1'b0;
      vb     <= 1'b0;
      sh     <= '0;
      data   <= '0;
      nine   <= 1'b0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (tick) begin
        if (!active) begin
          if (en && mode != MD_SHIFT && !s2) begin
            active <= 1'b1;
            sub    <= '0;
            bitn   <= '0;
          end
        end else begin
          sub <= idx;
          if (idx == V_A) va <= s2;
          if (idx == V_B) vb <= s2;
          if (idx == '0) bitn <= bitn + 4'd1;
          if (idx == V_C) begin
            if (bitn == 4'd0) begin
              if (bitv) active <= 1'b0;
            end else if (bitn == stop_n) begin
              active <= 1'b0;
              if (frame_ok) begin
                data <= nine_bit(mode) ? sh[7:0] : sh[8:1];
                if (nine_bit(mode)) nine <= sh[8];
              end
            end else begin
              sh <= {bitv, sh[8:1]};
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/multimode_serial.sv
module multimode_serial import sp_pkg::*; #(
  parameter int SYNC_DIV = 12,
  parameter int FIX_DIV  = 64,
  parameter int OVS      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ovf_strobe,
  input  logic       rxd,
  output logic       ser_out,
  output logic       shift_clk,
  output logic       tx_flag,
  output logic       rx_flag
);
  sp_mode_e   mode_q;
  logic       rxen_q, tx9_q, dbl_q, txf_q, rxf_q;
  logic       ctrl_wr, data_wr;
  logic       tick;
  logic       tx_busy, tx_end, rx_end, rx9;
  logic [7:0] rx_byte;

  assign ctrl_wr = reg_we & reg_sel;
  assign data_wr = reg_we & ~reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_SHIFT;
      rxen_q <= 1'b0;
      tx9_q  <= 1'b0;
      dbl_q  <= 1'b0;
      txf_q  <= 1'b0;
      rxf_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= sp_mode_e'(reg_wdata[1:0]);
        rxen_q <= reg_wdata[CB_RXEN];
        tx9_q  <= reg_wdata[CB_TX9];
        dbl_q  <= reg_wdata[CB_DBL];
      end
      // set wins; only a write of 0 clears
      txf_q <= tx_end | (txf_q & ~(ctrl_wr & ~reg_wdata[CB_TXF]));
      rxf_q <= rx_end | (rxf_q & ~(ctrl_wr & ~reg_wdata[CB_RXF]));
    end
  end

  sp_tick #(.FIX_DIV(FIX_DIV), .OVS(OVS)) i_tick (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .dbl(dbl_q),
    .ovf(ovf_strobe), .tick(tick)
  );

  sp_tx #(.SYNC_DIV(SYNC_DIV), .OVS(OVS)) i_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .tick(tick),
    .start(data_wr), .data(reg_wdata), .b9(tx9_q),
    .ser_out(ser_out), .shift_clk(shift_clk), .busy(tx_busy), .done(tx_end)
  );

  sp_rx #(.OVS(OVS)) i_rx (
    .clk(clk), .rst_n(rst_n), .en(rxen_q), .mode(mode_q), .tick(tick),
    .rxd(rxd), .data(rx_byte), .nine(rx9), .frame_ok(rx_end)
  );

  assign reg_rdata = reg_sel ? {dbl_q, rxf_q, txf_q, rx9, tx9_q, rxen_q, mode_q} : rx_byte;
  assign tx_flag   = txf_q;
  assign rx_flag   = rxf_q;

endmodule

// File: rtl/sp_checks.sv
module sp_checks import sp_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_busy,
  input logic       tx_end,
  input logic       rx_end,
  input logic       rx_on,
  input logic       ser_out,
  input logic       shift_clk,
  input logic       tx_flag,
  input logic       rx_flag,
  input logic       reg_we,
  input logic       reg_sel,
  input logic [7:0] reg_wdata,
  input sp_mode_e   mode
);

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (ser_out && shift_clk));

  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_busy) && mode != MD_SHIFT) |-> !ser_out);

  a_r12_txf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> $past(tx_end));

  a_r12_rxf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(rx_end));

  a_r12_txf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flag && !(reg_we && reg_sel && !reg_wdata[CB_TXF])) |=> tx_flag);

  a_r12_rxf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !(reg_we && reg_sel && !reg_wdata[CB_RXF])) |=> rx_flag);

  a_r11_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> rx_on);

endmodule

bind multimode_serial sp_checks u_sp_checks (
  .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .tx_end(tx_end), .rx_end(rx_end),
  .rx_on(rxen_q), .ser_out(ser_out), .shift_clk(shift_clk), .tx_flag(tx_flag),
  .rx_flag(rx_flag), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .mode(mode_q)
);

// File: tb/test_multimode_serial.sv
module test_multimode_serial;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we, reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  logic       ovf, rxd;
  logic       ser_out, shift_clk, tx_flag, rx_flag;

  int errors = 0;
  int checks = 0;
  int ovf_per = 0;
  int oc = 0;
  logic [1:0] c_mode;
  logic c_rxen, c_b9, c_dbl;

  multimode_serial i_multimode_serial (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_strobe(ovf), .rxd(rxd),
    .ser_out(ser_out), .shift_clk(shift_clk), .tx_flag(tx_flag), .rx_flag(rx_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  // overflow pulse generator
  always @(negedge clk) begin
    if (ovf_per > 0) begin
      oc = (oc + 1 >= ovf_per) ? 0 : oc + 1;
      ovf = (oc == 0);
    end else begin
      ovf = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic cfg(input logic [1:0] m, input logic re, input logic b9, input logic db);
    c_mode = m; c_rxen = re; c_b9 = b9; c_dbl = db;
    wr(1'b1, {db, 2'b11, 1'b0, b9, re, m});
  endtask

  task automatic clr_flags();
    wr(1'b1, {c_dbl, 2'b00, 1'b0, c_b9, c_rxen, c_mode});
  endtask

  task automatic wait_txf(input string tag);
    int n = 0;
    while (!tx_flag && n < 20000) begin @(negedge clk); n++; end
    chk(tag, tx_flag, 1);
  endtask

  function automatic logic [10:0] frame(input logic [7:0] d, input logic b9, input logic nine);
    logic [10:0] f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    if (nine) f[9] = b9;
    return f;
  endfunction

  task automatic cap_frame(input int bitp, input int nb, output logic [10:0] bits);
    int n = 0;
    bits = '1;
    while (ser_out && n < 20000) begin @(negedge clk); n++; end
    repeat (bitp/2) @(negedge clk);
    bits[0] = ser_out;
    for (int i = 1; i < nb; i++) begin
      repeat (bitp) @(negedge clk);
      bits[i] = ser_out;
    end
  endtask

  // data 55h: first data bit 1, second 0 -> one exact bit between edges
  task automatic meas_bit(input string tag, input int exp);
    int n = 0;
    int p = 0;
    wr(1'b0, 8'h55);
    while (ser_out && n < 20000) begin @(negedge clk); n++; end
    while (!ser_out && n < 20000) begin @(negedge clk); n++; end
    while (ser_out && n < 20000) begin @(negedge clk); n++; p++; end
    chk(tag, p, exp);
    wait_txf(tag);
    clr_flags();
  endtask

  task automatic send_rx(input int bitp, input int nb, input logic [10:0] bits, input int gbit);
    @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = bits[i];
      if (i == gbit) begin
        repeat (bitp/2 - 1) @(negedge clk);
        rxd = ~bits[i];
        repeat (3) @(negedge clk);
        rxd = bits[i];
        repeat (bitp - bitp/2 - 2) @(negedge clk);
      end else begin
        repeat (bitp) @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (bitp) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 ser_out", ser_out, 1);
    chk("R1 shift_clk", shift_clk, 1);
    chk("R1 tx_flag", tx_flag, 0);
    chk("R1 rx_flag", rx_flag, 0);
    rd(1'b1, v);
    chk("R1 control", v, 8'h00);
  endtask

  task automatic t_mode0();
    logic [7:0] got = '0;
    logic [7:0] v;
    logic prev;
    int t = 0, last = 0, k = 0;
    bit spacing_ok = 1;
    cfg(2'b00, 1'b0, 1'b0, 1'b0);
    wr(1'b0, 8'hA5);
    prev = shift_clk;
    while (k < 8 && t < 2000) begin
      @(negedge clk); t++;
      if (!prev && shift_clk) begin
        got[k] = ser_out;
        if (k > 0 && t - last != 12) spacing_ok = 0;
        last = t; k++;
      end
      prev = shift_clk;
    end
    chk("R2 shifted byte", got, 8'hA5);
    chk("R2 bit spacing 12", spacing_ok, 1);
    wait_txf("R12 tx flag after shift");
    chk("R2 shift_clk idle", shift_clk, 1);
    rd(1'b1, v);
    chk("R12 tx flag in bit 5", v[5], 1);
    wr(1'b1, 8'b0110_0000);
    chk("R12 write 1 keeps tx flag", tx_flag, 1);
    clr_flags();
    chk("R12 write 0 clears tx flag", tx_flag, 0);
  endtask

  task automatic t_async_tx();
    logic [10:0] b;
    cfg(2'b10, 1'b0, 1'b1, 1'b0);
    wr(1'b0, 8'h3A);
    cap_frame(64, 11, b);
    chk("R3 mode2 frame ninth=1", b, frame(8'h3A, 1'b1, 1'b1));
    wait_txf("R12 tx flag mode2"); clr_flags();
    cfg(2'b10, 1'b0, 1'b0, 1'b0);
    wr(1'b0, 8'hC5);
    cap_frame(64, 11, b);
    chk("R3 mode2 frame ninth=0", b, frame(8'hC5, 1'b0, 1'b1));
    wait_txf("R12 tx flag mode2b"); clr_flags();
    ovf_per = 3;
    cfg(2'b01, 1'b0, 1'b1, 1'b0);
    wr(1'b0, 8'h96);
    cap_frame(96, 11, b);
    chk("R3 mode1 frame no ninth", b, frame(8'h96, 1'b0, 1'b0));
    wait_txf("R12 tx flag mode1"); clr_flags();
  endtask

  task automatic t_rates();
    cfg(2'b10, 1'b0, 1'b0, 1'b0); meas_bit("R4 mode2 normal", 64);
    cfg(2'b10, 1'b0, 1'b0, 1'b1); meas_bit("R4 mode2 doubled", 32);
    ovf_per = 3;
    cfg(2'b01, 1'b0, 1'b0, 1'b0); meas_bit("R5 mode1 normal", 96);
    cfg(2'b01, 1'b0, 1'b0, 1'b1); meas_bit("R5 mode1 doubled", 48);
    ovf_per = 2;
    cfg(2'b11, 1'b0, 1'b1, 1'b1); meas_bit("R5 mode3 doubled", 32);
  endtask

  task automatic t_busy_write();
    logic [10:0] b;
    bit quiet = 1;
    cfg(2'b10, 1'b0, 1'b0, 1'b0);
    wr(1'b0, 8'h0F);
    fork
      cap_frame(64, 11, b);
      begin repeat (200) @(negedge clk); wr(1'b0, 8'hF0); end
    join
    chk("R6 frame unchanged", b, frame(8'h0F, 1'b0, 1'b1));
    wait_txf("R6 tx flag"); clr_flags();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!ser_out) quiet = 0;
    end
    chk("R6 no second frame", quiet, 1);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    ovf_per = 3;
    cfg(2'b10, 1'b1, 1'b0, 1'b0);
    send_rx(64, 11, frame(8'hA4, 1'b0, 1'b1), 3);
    chk("R12 rx flag set", rx_flag, 1);
    rd(1'b0, v); chk("R8 glitch rejected", v, 8'hA4);
    rd(1'b1, v); chk("R7 ninth 0 in bit 4", v[4], 0);
    clr_flags();
    chk("R12 rx flag cleared", rx_flag, 0);
    send_rx(64, 11, frame(8'h5B, 1'b1, 1'b1), -1);
    rd(1'b0, v); chk("R7 mode2 byte", v, 8'h5B);
    rd(1'b1, v); chk("R7 ninth 1 in bit 4", v[4], 1);
    clr_flags();
    cfg(2'b01, 1'b1, 1'b0, 1'b0);
    send_rx(96, 10, frame(8'h3C, 1'b0, 1'b0), -1);
    chk("R7 mode1 rx flag", rx_flag, 1);
    rd(1'b0, v); chk("R7 mode1 byte", v, 8'h3C);
    rd(1'b1, v); chk("R7 mode1 keeps bit 4", v[4], 1);
    clr_flags();
  endtask

  task automatic t_rx_reject();
    logic [7:0] v;
    logic [10:0] f;
    cfg(2'b10, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R9 false start no flag", rx_flag, 0);
    send_rx(64, 11, frame(8'h11, 1'b0, 1'b1), -1);
    rd(1'b0, v); chk("R9 next frame received", v, 8'h11);
    clr_flags();
    f = frame(8'h77, 1'b0, 1'b1);
    f[10] = 1'b0;
    send_rx(64, 11, f, -1);
    repeat (200) @(negedge clk);
    chk("R10 bad stop no flag", rx_flag, 0);
    rd(1'b0, v); chk("R10 buffer unchanged", v, 8'h11);
    cfg(2'b10, 1'b0, 1'b0, 1'b0);
    send_rx(64, 11, frame(8'h22, 1'b0, 1'b1), -1);
    chk("R11 disabled no flag", rx_flag, 0);
    rd(1'b0, v); chk("R11 buffer unchanged", v, 8'h11);
  endtask

  initial begin
    rst_n = 1'b0; rxd = 1'b1; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    c_mode = 2'b00; c_rxen = 1'b0; c_b9 = 1'b0; c_dbl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_async_tx();
    t_rates();
    t_busy_write();
    t_rx();
    t_rx_reject();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule